// File: doc/BRIEF.md
# LCD Raster Timing Controller

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable qualifier and the panel clock. Software programs the timing, polarity, divider and control values through a simple single-cycle register port. A programmable divider turns the system clock into a pixel-rate clock enable, and all raster counters advance only on that enable, so the whole block lives in one clock domain.

The block also holds the frame base address in two stages. A software write lands in a shadow register, which is copied to the active base at the next frame start. That copy raises an interrupt status bit, which has an enable mask and a write-one-to-clear register. A two-step power interlock stops the panel supply from being switched on before the controller is enabled, or the controller from being disabled while the panel is still powered. The block exposes the current line number, a frame counter, a per-active-pixel fetch request strobe for a downstream pixel engine, and an alternating bias output for monochrome panels.

Top module: `lcdt_top`

## Requirements
- R1: After reset all registers read zero. hsync_o, vsync_o, de_o, panel_pwr_o, irq_o and acb_o are low, and base_o, line_o and frame_o are zero.
- R2: Each line is made of phases in this order: sync for HTIM[7:0]+1 pixels, back porch for HTIM[15:8]+1 pixels, active for 16*(HTIM[29:24]+1) pixels, then front porch for HTIM[23:16]+1 pixels. HTIM is at address 0. hsync_o is high (when not inverted) during the sync phase.
- R3: Lines count in this order: sync for VTIM[15:10]+1 lines, back porch for exactly VTIM[31:24] lines (zero is allowed), active for VTIM[9:0]+1 lines, then front porch for exactly VTIM[23:16] lines. VTIM is at address 1. vsync_o is high (when not inverted) during the sync lines.
- R4: de_o is high (when not inverted) only on a pixel that is in both the active pixel phase and the active line phase.
- R5: CFG (address 2) bit 10 inverts hsync_o, bit 11 inverts vsync_o and bit 12 inverts de_o. The inversion also applies to the idle levels.
- R6: Without bypass, one pixel lasts {CFG[19:15],CFG[4:0]}+2 system clocks. With CFG[14] set, one pixel lasts one system clock.
- R7: In divided mode, with CFG[13]=0, pclk_o is high during the first floor(D/2) clocks of each pixel period, where D is the divisor. The raster outputs change as pclk_o rises. With CFG[13]=1, pclk_o is inverted, so the outputs change on its falling edge.
- R8: A write to BASE (address 3) does not change base_o. The value is copied to base_o at the next frame start, which is the step from the last pixel of the last line to pixel 0 of line 0.
- R9: Every frame start sets raw status bit 0 (read at address 6). irq_o and the masked status (address 7) equal the raw status ANDed with IEN bit 0 (address 5). Writing 1 to ICR bit 0 (address 8) clears the raw status, but a frame start in the same cycle wins and leaves it set.
- R10: CTRL (address 4) holds bit 0 enable, bit 1 panel power and bit 2 monochrome. Power is accepted only if enable was already set before the write. Enable is cleared only by a write made while power is already off.
- R11: line_o gives the current line number. frame_o counts frame starts. fetch_req_o pulses once per active pixel, so it pulses 16*(HTIM[29:24]+1)*(VTIM[9:0]+1) times per frame.
- R12: With monochrome set and the controller enabled, acb_o toggles after every CFG[9:5]+1 frame starts. Otherwise acb_o is low.
- R13: While enable is clear, the counters stay at pixel 0 of line 0, and sync and data-enable sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Panel clock |
| panel_pwr_o | output | 1 | Panel power control |
| acb_o | output | 1 | Alternating bias for monochrome panels |
| fetch_req_o | output | 1 | One strobe per active pixel |
| irq_o | output | 1 | Masked next-base interrupt |
| base_o | output | 32 | Active frame base address |
| line_o | output | 11 | Current line number |
| frame_o | output | 16 | Frame start counter |

## Verification
The frame-start event and a software write-one-to-clear to the status can both fall on the same clock edge. The two collide over the status bit, and the set must win. The bench provokes the collision in bypass mode, where the frame length in clocks is known from the programmed timing. It counts clocks from the enabling write and places the clear so that its write edge is exactly the frame-start edge. It then judges the result by reading the raw status back as one and seeing irq_o still high. The same frame-start edge is also checked on its own, for the shadow-to-active base copy.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int DW        = 32;
  localparam int AW        = 4;
  localparam int HFW       = 8;   // horizontal sync/porch field width
  localparam int PPLW      = 6;   // active width field, in 16-pixel groups
  localparam int LPPW      = 10;  // active lines field
  localparam int VSWW      = 6;   // vertical sync field
  localparam int VPW       = 8;   // vertical porch fields
  localparam int DIVW      = 5;   // each divider half
  localparam int DIVVW     = 2 * DIVW;
  localparam int ACBW      = 5;
  localparam int GRP_LOG2  = 4;
  localparam int HCW       = 12;
  localparam int VCW       = 11;
  localparam int FCW       = 16;

  localparam int HBP_LSB   = HFW;
  localparam int HFP_LSB   = 2 * HFW;
  localparam int PPL_LSB   = 3 * HFW;
  localparam int VSW_LSB   = LPPW;
  localparam int VFP_LSB   = LPPW + VSWW;
  localparam int VBP_LSB   = VFP_LSB + VPW;
  localparam int ACB_LSB   = DIVW;
  localparam int IHS_BIT   = DIVW + ACBW;
  localparam int IVS_BIT   = IHS_BIT + 1;
  localparam int IDE_BIT   = IHS_BIT + 2;
  localparam int FALL_BIT  = IHS_BIT + 3;
  localparam int BYP_BIT   = IHS_BIT + 4;
  localparam int DHI_LSB   = IHS_BIT + 5;

  localparam logic [AW-1:0] A_HTIM = 4'd0;
  localparam logic [AW-1:0] A_VTIM = 4'd1;
  localparam logic [AW-1:0] A_CFG  = 4'd2;
  localparam logic [AW-1:0] A_BASE = 4'd3;
  localparam logic [AW-1:0] A_CTRL = 4'd4;
  localparam logic [AW-1:0] A_IEN  = 4'd5;
  localparam logic [AW-1:0] A_RIS  = 4'd6;
  localparam logic [AW-1:0] A_MIS  = 4'd7;
  localparam logic [AW-1:0] A_ICR  = 4'd8;

  typedef struct packed {
    logic [HFW-1:0]  hsw;
    logic [HFW-1:0]  hbp;
    logic [HFW-1:0]  hfp;
    logic [PPLW-1:0] ppl;
    logic [LPPW-1:0] lpp;
    logic [VSWW-1:0] vsw;
    logic [VPW-1:0]  vbp;
    logic [VPW-1:0]  vfp;
  } tim_cfg_t;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             frame_start,
  output tim_cfg_t         tim_o,
  output logic [DIVVW-1:0] div_o,
  output logic             bypass_o,
  output logic             ihs_o,
  output logic             ivs_o,
  output logic             ide_o,
  output logic             fall_o,
  output logic [ACBW-1:0]  acb_o,
  output logic             en_o,
  output logic             pwr_o,
  output logic             mono_o,
  output logic [DW-1:0]    base_o,
  output logic             irq_o
);
  logic [DW-1:0] htim_q, htim_n, vtim_q, vtim_n, cfg_q, cfg_n;
  logic [DW-1:0] shadow_q, shadow_n, base_q, base_n;
  logic          en_q, en_n, pwr_q, pwr_n, mono_q, mono_n;
  logic          ien_q, ien_n, ris_q, ris_n;

  always_comb begin
    htim_n   = htim_q;
    vtim_n   = vtim_q;
    cfg_n    = cfg_q;
    shadow_n = shadow_q;
    base_n   = base_q;
    en_n     = en_q;
    pwr_n    = pwr_q;
    mono_n   = mono_q;
    ien_n    = ien_q;
    ris_n    = ris_q;
    if (wr_en) begin
      case (wr_addr)
        A_HTIM: htim_n   = wr_data;
        A_VTIM: vtim_n   = wr_data;
        A_CFG:  cfg_n    = wr_data;
        A_BASE: shadow_n = wr_data;
        A_CTRL: begin
          en_n   = wr_data[0] | pwr_q;
          pwr_n  = wr_data[1] & en_q;
          mono_n = wr_data[2];
        end
        A_IEN:  ien_n = wr_data[0];
        A_ICR:  if (wr_data[0]) ris_n = 1'b0;
        default: ;
      endcase
    end
    if (frame_start) begin
      base_n = shadow_q;
      ris_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htim_q   <= '0;
      vtim_q   <= '0;
      cfg_q    <= '0;
      shadow_q <= '0;
      base_q   <= '0;
      en_q     <= 1'b0;
      pwr_q    <= 1'b0;
      mono_q   <= 1'b0;
      ien_q    <= 1'b0;
      ris_q    <= 1'b0;
    end else begin
      htim_q   <= htim_n;
      vtim_q   <= vtim_n;
      cfg_q    <= cfg_n;
      shadow_q <= shadow_n;
      base_q   <= base_n;
      en_q     <= en_n;
      pwr_q    <= pwr_n;
      mono_q   <= mono_n;
      ien_q    <= ien_n;
      ris_q    <= ris_n;
    end
  end

  always_comb begin
    case (rd_addr)
      A_HTIM:  rd_data = htim_q;
      A_VTIM:  rd_data = vtim_q;
      A_CFG:   rd_data = cfg_q;
      A_BASE:  rd_data = shadow_q;
      A_CTRL:  rd_data = {{(DW-3){1'b0}}, mono_q, pwr_q, en_q};
      A_IEN:   rd_data = {{(DW-1){1'b0}}, ien_q};
      A_RIS:   rd_data = {{(DW-1){1'b0}}, ris_q};
      A_MIS:   rd_data = {{(DW-1){1'b0}}, ris_q & ien_q};
      default: rd_data = '0;
    endcase
  end

  assign tim_o.hsw = htim_q[HFW-1:0];
  assign tim_o.hbp = htim_q[HBP_LSB +: HFW];
  assign tim_o.hfp = htim_q[HFP_LSB +: HFW];
  assign tim_o.ppl = htim_q[PPL_LSB +: PPLW];
  assign tim_o.lpp = vtim_q[LPPW-1:0];
  assign tim_o.vsw = vtim_q[VSW_LSB +: VSWW];
  assign tim_o.vfp = vtim_q[VFP_LSB +: VPW];
  assign tim_o.vbp = vtim_q[VBP_LSB +: VPW];
  assign div_o     = {cfg_q[DHI_LSB +: DIVW], cfg_q[DIVW-1:0]};
  assign acb_o     = cfg_q[ACB_LSB +: ACBW];
  assign ihs_o     = cfg_q[IHS_BIT];
  assign ivs_o     = cfg_q[IVS_BIT];
  assign ide_o     = cfg_q[IDE_BIT];
  assign fall_o    = cfg_q[FALL_BIT];
  assign bypass_o  = cfg_q[BYP_BIT];
  assign en_o      = en_q;
  assign pwr_o     = pwr_q;
  assign mono_o    = mono_q;
  assign base_o    = base_q;
  assign irq_o     = ris_q & ien_q;

  // R10
  pwr_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_q) |-> $past(en_q));
  // R10
  en_drop_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !$past(pwr_q));
  // R8
  base_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> $past(frame_start));
  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ris_q);
endmodule

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIVVW-1:0] div_i,
  input  logic             bypass_i,
  input  logic             fall_i,
  output logic             pix_ce_o,
  output logic             pclk_o
);
  localparam int CW = DIVVW + 1;

  logic [CW-1:0] cnt_q, cnt_n, last, half;
  logic          pclk_q, pclk_n;

  always_comb begin
    last = CW'(div_i) + CW'(1);
    half = (CW'(div_i) + CW'(2)) >> 1;
    if (bypass_i || cnt_q >= last) cnt_n = '0;
    else                           cnt_n = cnt_q + CW'(1);
    pclk_n = (cnt_n < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pclk_q <= pclk_n;
    end
  end

  assign pix_ce_o = bypass_i | (cnt_q >= last);
  assign pclk_o   = (bypass_i ? clk : pclk_q) ^ fall_i;

  // R6
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce_o && !bypass_i) |=> (!pix_ce_o || bypass_i));
endmodule

// File: rtl/lcdt_timing.sv
module lcdt_timing
  import lcdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_ce_i,
  input  logic            en_i,
  input  tim_cfg_t        tim_i,
  input  logic            ihs_i,
  input  logic            ivs_i,
  input  logic            ide_i,
  input  logic            mono_i,
  input  logic [ACBW-1:0] acb_max_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            fetch_o,
  output logic            frame_start_o,
  output logic [VCW-1:0]  line_o,
  output logic [FCW-1:0]  frame_o,
  output logic            acb_o
);
  logic [HCW-1:0]  hcnt_q, hcnt_n, h_se, h_as, h_ae, h_tot;
  logic [VCW-1:0]  vcnt_q, vcnt_n, v_se, v_as, v_ae, v_tot;
  logic [FCW-1:0]  frm_q, frm_n;
  logic [ACBW-1:0] acnt_q, acnt_n;
  logic            acb_q, acb_n;
  logic            hlast, vlast, fs, hs_a, vs_a, de_a;
  logic [2:0]      act, pol, outv;

  always_comb begin
    h_se  = HCW'(tim_i.hsw) + HCW'(1);
    h_as  = h_se + HCW'(tim_i.hbp) + HCW'(1);
    h_ae  = h_as + ((HCW'(tim_i.ppl) + HCW'(1)) << GRP_LOG2);
    h_tot = h_ae + HCW'(tim_i.hfp) + HCW'(1);
    v_se  = VCW'(tim_i.vsw) + VCW'(1);
    v_as  = v_se + VCW'(tim_i.vbp);
    v_ae  = v_as + VCW'(tim_i.lpp) + VCW'(1);
    v_tot = v_ae + VCW'(tim_i.vfp);
    hlast = (hcnt_q >= h_tot - HCW'(1));
    vlast = (vcnt_q >= v_tot - VCW'(1));
    fs    = en_i & pix_ce_i & hlast & vlast;
  end

  always_comb begin
    hcnt_n = hcnt_q;
    vcnt_n = vcnt_q;
    frm_n  = frm_q;
    acnt_n = acnt_q;
    acb_n  = acb_q;
    if (!en_i) begin
      hcnt_n = '0;
      vcnt_n = '0;
    end else if (pix_ce_i) begin
      if (hlast) begin
        hcnt_n = '0;
        vcnt_n = vlast ? '0 : vcnt_q + VCW'(1);
      end else begin
        hcnt_n = hcnt_q + HCW'(1);
      end
    end
    if (fs) frm_n = frm_q + FCW'(1);
    if (!en_i || !mono_i) begin
      acnt_n = '0;
      acb_n  = 1'b0;
    end else if (fs) begin
      if (acnt_q >= acb_max_i) begin
        acnt_n = '0;
        acb_n  = ~acb_q;
      end else begin
        acnt_n = acnt_q + ACBW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
      frm_q  <= '0;
      acnt_q <= '0;
      acb_q  <= 1'b0;
    end else begin
      hcnt_q <= hcnt_n;
      vcnt_q <= vcnt_n;
      frm_q  <= frm_n;
      acnt_q <= acnt_n;
      acb_q  <= acb_n;
    end
  end

  assign hs_a = en_i & (hcnt_q < h_se);
  assign vs_a = en_i & (vcnt_q < v_se);
  assign de_a = en_i & (hcnt_q >= h_as) & (hcnt_q < h_ae)
                     & (vcnt_q >= v_as) & (vcnt_q < v_ae);

  assign act = {hs_a, vs_a, de_a};
  assign pol = {ihs_i, ivs_i, ide_i};
  for (genvar i = 0; i < 3; i++) begin : g_pol
    assign outv[i] = act[i] ^ pol[i];
  end
  assign {hsync_o, vsync_o, de_o} = outv;

  assign fetch_o       = de_a & pix_ce_i;
  assign frame_start_o = fs;
  assign line_o        = vcnt_q;
  assign frame_o       = frm_q;
  assign acb_o         = acb_q;

  // R3
  vs_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_a) |-> (hcnt_q == '0));
endmodule

// File: rtl/lcdt_top.sv
module lcdt_top
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pclk_o,
  output logic          panel_pwr_o,
  output logic          acb_o,
  output logic          fetch_req_o,
  output logic          irq_o,
  output logic [31:0]   base_o,
  output logic [10:0]   line_o,
  output logic [15:0]   frame_o
);
  logic [1:0]       rs_q;
  logic             srst_n;
  tim_cfg_t         tim;
  logic [DIVVW-1:0] div;
  logic [ACBW-1:0]  acb_max;
  logic             bypass, ihs, ivs, ide, fall, en, mono, pix_ce, fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  lcdt_regs u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(fs), .tim_o(tim), .div_o(div), .bypass_o(bypass),
    .ihs_o(ihs), .ivs_o(ivs), .ide_o(ide), .fall_o(fall), .acb_o(acb_max),
    .en_o(en), .pwr_o(panel_pwr_o), .mono_o(mono), .base_o(base_o),
    .irq_o(irq_o)
  );

  lcdt_clkdiv u_div (
    .clk(clk), .rst_n(srst_n), .div_i(div), .bypass_i(bypass),
    .fall_i(fall), .pix_ce_o(pix_ce), .pclk_o(pclk_o)
  );

  lcdt_timing u_tim (
    .clk(clk), .rst_n(srst_n), .pix_ce_i(pix_ce), .en_i(en), .tim_i(tim),
    .ihs_i(ihs), .ivs_i(ivs), .ide_i(ide), .mono_i(mono),
    .acb_max_i(acb_max), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .fetch_o(fetch_req_o), .frame_start_o(fs), .line_o(line_o),
    .frame_o(frame_o), .acb_o(acb_o)
  );
endmodule

// File: tb/tb_lcdt_top.sv
module tb_lcdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        hsync_o, vsync_o, de_o, pclk_o, panel_pwr_o, acb_o;
  logic        fetch_req_o, irq_o;
  logic [31:0] base_o;
  logic [10:0] line_o;
  logic [15:0] frame_o;

  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  int          fcount = 0;
  int          exp_fetch = 0;
  bit          mon_on = 1'b0;
  string       sb_tag = "R2 R3 R4 R11";
  logic [13:0] q[$];

  lcdt_top dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // driver: expected raster for one frame, one item per pixel (bypass mode)
  task automatic push_frame(input int hsw, hbp, hfp, ppl, vsw, vbp, lpp, vfp,
                            input bit ih, iv, id);
    int hse, has, hae, ht, vse, vas, vae, vt;
    hse = hsw + 1; has = hse + hbp + 1; hae = has + 16 * (ppl + 1); ht = hae + hfp + 1;
    vse = vsw + 1; vas = vse + vbp; vae = vas + lpp + 1; vt = vae + vfp;
    exp_fetch = 16 * (ppl + 1) * (lpp + 1);
    for (int v = 0; v < vt; v++)
      for (int h = 0; h < ht; h++) begin
        logic hs, vs, de;
        hs = (h < hse) ^ ih;
        vs = (v < vse) ^ iv;
        de = ((h >= has) && (h < hae) && (v >= vas) && (v < vae)) ^ id;
        q.push_back({11'(v), hs, vs, de});
      end
  endtask

  // monitor: pops one expected pixel per clock
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_on && q.size() > 0) begin
        logic [13:0] e;
        e = q.pop_front();
        chk(sb_tag, {18'd0, line_o, hsync_o, vsync_o, de_o}, {18'd0, e});
        if (fetch_req_o) fcount++;
      end
    end
  end

  task automatic meas(output int per, output logic pc);
    int r[3];
    int n;
    logic prev;
    n = 0;
    @(negedge clk); #1;
    prev = hsync_o;
    while (n < 3) begin
      @(negedge clk); #1;
      if (hsync_o && !prev) begin
        r[n] = cyc;
        if (n == 1) pc = pclk_o;
        n++;
      end
      prev = hsync_o;
    end
    per = r[2] - r[1];
  endtask

  task automatic run_frame(input string tag);
    sb_tag = tag;
    fcount = 0;
    wr(4'd4, 32'd1);
    mon_on = 1'b1;
    wait (q.size() == 0);
    mon_on = 1'b0;
  endtask

  localparam logic [31:0] HTIM_A = 32'h0;
  localparam logic [31:0] VTIM_A = 32'h0101_0001;
  localparam logic [31:0] HTIM_B = 32'h0002_0101;
  localparam logic [31:0] VTIM_B = 32'h0002_0400;
  localparam logic [31:0] BYP    = 32'h0000_4000;
  localparam int          PA     = 95;

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, f0, per;
    logic pc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 hsync", hsync_o, 0); chk("R1 vsync", vsync_o, 0); chk("R1 de", de_o, 0);
    chk("R1 pwr", panel_pwr_o, 0); chk("R1 irq", irq_o, 0); chk("R1 acb", acb_o, 0);
    chk("R1 base", base_o, 0); chk("R1 line", line_o, 0); chk("R1 frame", frame_o, 0);
    rd(4'd4, d); chk("R1 ctrl", d, 0);
    rd(4'd2, d); chk("R1 cfg", d, 0);

    // pattern A, normal polarity
    wr(4'd0, HTIM_A); wr(4'd1, VTIM_A); wr(4'd2, BYP);
    push_frame(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
    run_frame("R2 R3 R4 R11 pattern A");
    chk("R11 fetch count A", fcount, exp_fetch);
    @(negedge clk); #1;
    chk("R11 frame count", frame_o, 1);
    chk("R11 line after wrap", line_o, 0);
    rd(4'd6, d); chk("R9 raw status set", d, 1);
    chk("R9 irq masked", irq_o, 0);
    wr(4'd4, 32'd0); #1;
    chk("R13 hsync idle", hsync_o, 0);
    chk("R13 line held", line_o, 0);
    repeat (30) @(negedge clk); #1;
    chk("R13 line still held", line_o, 0);
    wr(4'd8, 32'd1);
    rd(4'd6, d); chk("R9 raw status cleared", d, 0);

    // pattern B, all polarities inverted, zero back porch lines
    wr(4'd0, HTIM_B); wr(4'd1, VTIM_B); wr(4'd2, BYP | 32'h1C00);
    push_frame(1, 1, 2, 0, 1, 0, 0, 2, 1, 1, 1);
    run_frame("R2 R3 R4 R5 pattern B");
    chk("R11 fetch count B", fcount, exp_fetch);
    wr(4'd4, 32'd0); #1;
    chk("R5 R13 hsync idle inverted", hsync_o, 1);
    chk("R5 R13 vsync idle inverted", vsync_o, 1);
    chk("R5 R13 de idle inverted", de_o, 1);
    wr(4'd8, 32'd1);

    // base double buffer and interrupt
    wr(4'd0, HTIM_A); wr(4'd1, VTIM_A); wr(4'd2, BYP);
    wr(4'd5, 32'd1);
    wr(4'd3, 32'hA5A5_0010); #1;
    chk("R8 base not immediate", base_o, 0);
    wr(4'd4, 32'd1);
    c0 = cyc;
    while (cyc < c0 + 50) @(negedge clk);
    #1; chk("R8 base held mid-frame", base_o, 0);
    while (cyc < c0 + PA) @(negedge clk);
    #1; chk("R8 base latched at frame start", base_o, 32'hA5A5_0010);
    chk("R9 irq raised", irq_o, 1);
    rd(4'd7, d); chk("R9 masked status", d, 1);
    wr(4'd8, 32'd1); #1;
    rd(4'd6, d); chk("R9 clear", d, 0);
    chk("R9 irq cleared", irq_o, 0);
    while (cyc < c0 + 2 * PA - 2) @(negedge clk);
    wr(4'd8, 32'd1); #1;
    rd(4'd6, d); chk("R9 set wins over clear", d, 1);
    chk("R9 irq after collision", irq_o, 1);

    // power sequence
    wr(4'd4, 32'd0); wr(4'd8, 32'd1);
    wr(4'd4, 32'd3); #1;
    rd(4'd4, d); chk("R10 power refused without prior enable", d, 1);
    chk("R10 pwr pin low", panel_pwr_o, 0);
    wr(4'd4, 32'd3); #1;
    rd(4'd4, d); chk("R10 power accepted", d, 3);
    chk("R10 pwr pin high", panel_pwr_o, 1);
    wr(4'd4, 32'd0); #1;
    rd(4'd4, d); chk("R10 enable kept while powered", d, 1);
    chk("R10 pwr pin dropped", panel_pwr_o, 0);
    wr(4'd4, 32'd0); #1;
    rd(4'd4, d); chk("R10 enable cleared", d, 0);

    // divider and panel clock edge
    wr(4'd2, 32'd3);
    wr(4'd4, 32'd1);
    meas(per, pc);
    chk("R6 line period div 5", per, 19 * 5);
    chk("R7 pclk rising with data", pc, 1);
    wr(4'd2, 32'd3 | 32'h2000);
    meas(per, pc);
    chk("R6 line period div 5 fall", per, 19 * 5);
    chk("R7 pclk falling with data", pc, 0);
    wr(4'd2, 32'h0000_8000);
    meas(per, pc);
    chk("R6 line period high field", per, 19 * 34);
    wr(4'd2, BYP);
    meas(per, pc);
    chk("R6 line period bypass", per, 19);

    // alternating bias, toggle every two frames
    wr(4'd4, 32'd0);
    wr(4'd2, BYP | 32'h20);
    wr(4'd4, 32'd5); #1;
    chk("R12 acb start", acb_o, 0);
    f0 = frame_o;
    for (int k = 1; k <= 4; k++) begin
      while (int'(frame_o) != f0 + k) @(negedge clk);
      #1;
      chk($sformatf("R12 acb after frame %0d", k), acb_o, (k == 2 || k == 3) ? 1 : 0);
    end
    wr(4'd4, 32'd1); #1;
    chk("R12 acb low without mono", acb_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule